// File: doc/BRIEF.md
# Two-Wire Write-Only DAC Command Receiver

This block is a receive-only slave for a two-wire serial bus. It runs on a fast system clock that oversamples both bus lines. It cleans the SCL and SDA inputs and finds START and STOP conditions. It shifts in bytes MSB first and pulls SDA low through an open-drain enable to acknowledge each byte it accepts. The decoded results leave the block as single-cycle strobes. These strobes drive the latches of a 10-bit converter, which sit outside this block.

The block answers on two addresses. The first is its own address, whose low three bits come from strap inputs. On that address it takes either a command byte alone, or a command byte followed by a low and a high code byte. The second is a synchronisation address that many devices can share. There the bit after the address is a flag, not a direction bit. When a frame is cut short by a START or a STOP, the block keeps whatever was already acknowledged at the command level and drops the rest.

Top module: `twowire_dac_rx`

## Requirements
- R1: The own address is the 7-bit value {0100, strap[2:0]}. It is acknowledged only when the eighth bit (write flag) is 0. An address byte with the eighth bit set to 1, or any other address, is not acknowledged. No later byte is then acknowledged and no strobe fires until the next START.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Each STOP on the bus produces exactly one stop_seen pulse, and a STOP returns the receiver to idle.
- R3: On every accepted byte, sda_oe is high for the whole SCL high time of the following (ninth) clock. sda_oe changes only while the filtered SCL is low.
- R4: In a frame of address, command, low byte and high byte, cmd_valid pulses once with the command byte during the command acknowledge. data_valid pulses once during the high-byte acknowledge, with data_code = {high[1:0], low[7:0]}. Bits 7..2 of the high byte have no effect on data_code.
- R5: A frame of address and command only, closed by STOP, gives one cmd_valid and no data_valid.
- R6: A START or STOP that arrives before the command byte is acknowledged discards that command: no cmd_valid and no data_valid.
- R7: A START or STOP after the command acknowledge but before the high-byte acknowledge keeps the command (one cmd_valid) and produces no data_valid for that frame.
- R8: The synchronisation address 1111110 is acknowledged whatever its eighth bit. sync_ack pulses once on the SCL rise of that acknowledge clock, and sync_flag equals the eighth bit. Bytes after it are not acknowledged.
- R9: cmd_valid, data_valid, sync_ack and stop_seen are one-cycle pulses, and no two of them are high in the same cycle.
- R10: An SCL high glitch one system clock long is ignored: the byte it lands in is received unchanged.
- R11: After the high-byte acknowledge, further bytes in the same frame are not acknowledged and fire no strobe.
- R12: After reset sda_oe is 0, all strobes are 0, and cmd_byte, data_code and sync_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Low three bits of the own address |
| sda_oe | output | 1 | Pulls SDA low when high (open-drain acknowledge) |
| cmd_valid | output | 1 | One-cycle strobe: command byte accepted |
| cmd_byte | output | 8 | Last accepted command byte |
| data_valid | output | 1 | One-cycle strobe: code word accepted |
| data_code | output | 10 | Last accepted code word |
| stop_seen | output | 1 | One-cycle strobe on each STOP |
| sync_ack | output | 1 | One-cycle strobe on the synchronisation acknowledge |
| sync_flag | output | 1 | Flag bit of the last synchronisation address |

## Verification
The in-line properties check on every cycle that the strobes are exclusive single pulses. They also check that sda_oe never moves while SCL is high, that the data and sync strobes happen only while the acknowledge is driven, and that a STOP leaves the line released. Whether the right bytes are acknowledged, which partial frames keep their command, the code bit packing, address filtering and glitch rejection can only be shown by the bench's frames. These are seeded random full, short, sync and cut-off frames, with directed cases for wrong addresses, read bits, trailing bytes and SCL glitches.

// File: rtl/twowire_dac_rx.sv
module twowire_dac_rx #(
  parameter logic [3:0] ADDR_HI   = 4'b0100,
  parameter logic [6:0] SYNC_ADDR = 7'b1111110,
  parameter int         CODE_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [2:0]        strap,
  output logic              sda_oe,
  output logic              cmd_valid,
  output logic [7:0]        cmd_byte,
  output logic              data_valid,
  output logic [CODE_W-1:0] data_code,
  output logic              stop_seen,
  output logic              sync_ack,
  output logic              sync_flag
);
  localparam int HI_W = CODE_W - 8;

  typedef enum logic [2:0] {ST_IDLE, ST_BITS, ST_PREACK, ST_ACK, ST_HOLD} st_t;
  typedef enum logic [2:0] {SL_ADDR, SL_CMD, SL_LO, SL_HI, SL_SYNC} slot_t;

  logic [1:0] scl_sy, sda_sy;
  logic [2:0] scl_win, sda_win;
  logic       scl_f, sda_f, scl_q, sda_q;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy  <= '1;
      sda_sy  <= '1;
      scl_win <= '1;
      sda_win <= '1;
      scl_f   <= 1'b1;
      sda_f   <= 1'b1;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      scl_sy  <= {scl_sy[0], scl_in};
      sda_sy  <= {sda_sy[0], sda_in};
      scl_win <= {scl_win[1:0], scl_sy[1]};
      sda_win <= {sda_win[1:0], sda_sy[1]};
      scl_f   <= maj3(scl_win);
      sda_f   <= maj3(sda_win);
      scl_q   <= scl_f;
      sda_q   <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st;
  slot_t      slot;
  logic [2:0] bit_cnt;
  logic [7:0] shreg, lo_reg;
  logic       flag_reg;

  wire [7:0] rx_byte  = {shreg[6:0], sda_f};
  wire [6:0] own_addr = {ADDR_HI, strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      slot       <= SL_ADDR;
      bit_cnt    <= '0;
      shreg      <= '0;
      lo_reg     <= '0;
      flag_reg   <= 1'b0;
      sda_oe     <= 1'b0;
      cmd_valid  <= 1'b0;
      cmd_byte   <= '0;
      data_valid <= 1'b0;
      data_code  <= '0;
      stop_seen  <= 1'b0;
      sync_ack   <= 1'b0;
      sync_flag  <= 1'b0;
    end else begin
      cmd_valid  <= 1'b0;
      data_valid <= 1'b0;
      stop_seen  <= 1'b0;
      sync_ack   <= 1'b0;
      if (stop_ev) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        stop_seen <= 1'b1;
      end else if (start_ev) begin
        st      <= ST_BITS;
        slot    <= SL_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        case (st)
          ST_BITS: if (scl_rise) begin
            shreg   <= rx_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (slot != SL_ADDR) begin
                st <= ST_PREACK;
              end else if (rx_byte[7:1] == own_addr && !rx_byte[0]) begin
                st <= ST_PREACK;
              end else if (rx_byte[7:1] == SYNC_ADDR) begin
                flag_reg <= rx_byte[0];
                slot     <= SL_SYNC;
                st       <= ST_PREACK;
              end else begin
                st <= ST_HOLD;
              end
            end
          end
          ST_PREACK: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= ST_ACK;
          end
          ST_ACK: begin
            if (scl_rise) begin
              case (slot)
                SL_CMD: begin
                  cmd_valid <= 1'b1;
                  cmd_byte  <= shreg;
                end
                SL_LO: lo_reg <= shreg;
                SL_HI: begin
                  data_valid <= 1'b1;
                  data_code  <= {shreg[HI_W-1:0], lo_reg};
                end
                SL_SYNC: begin
                  sync_ack  <= 1'b1;
                  sync_flag <= flag_reg;
                end
                default: ;
              endcase
            end else if (scl_fall) begin
              sda_oe  <= 1'b0;
              bit_cnt <= '0;
              case (slot)
                SL_ADDR: begin slot <= SL_CMD; st <= ST_BITS; end
                SL_CMD:  begin slot <= SL_LO;  st <= ST_BITS; end
                SL_LO:   begin slot <= SL_HI;  st <= ST_BITS; end
                default: st <= ST_HOLD;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  oe_moves_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_f));
  // R4
  data_under_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> sda_oe);
  // R8
  sync_under_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack |-> sda_oe);
  // R2
  stop_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |-> !sda_oe);
  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cmd_valid, data_valid, sync_ack, stop_seen}) <= 1);
  // R9
  cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  // R9
  data_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |=> !data_valid);
endmodule

// File: tb/sim_twowire_dac_rx.sv
module sim_twowire_dac_rx;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0] strap = 3'b000;
  logic sda_oe, cmd_valid, data_valid, stop_seen, sync_ack, sync_flag;
  logic [7:0] cmd_byte;
  logic [9:0] data_code;
  wire sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  twowire_dac_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus), .strap(strap),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_code(data_code), .stop_seen(stop_seen),
    .sync_ack(sync_ack), .sync_flag(sync_flag));

  int n_chk = 0, n_bad = 0;
  int cmd_n = 0, dat_n = 0, stp_n = 0, syn_n = 0, multi_n = 0;
  logic [7:0] last_cmd;
  logic [9:0] last_code;
  logic last_flag;
  bit done = 0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) begin cmd_n++; last_cmd = cmd_byte; end
    if (data_valid) begin dat_n++; last_code = data_code; end
    if (stop_seen) stp_n++;
    if (sync_ack) begin syn_n++; last_flag = sync_flag; end
    if (int'(cmd_valid) + int'(data_valid) + int'(stop_seen) + int'(sync_ack) > 1) multi_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_code(input logic [7:0] lo, input logic [7:0] hi);
    return {hi[1:0], lo};
  endfunction
  function automatic logic [7:0] own_w(input logic [2:0] s);
    return {4'b0100, s, 1'b0};
  endfunction

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask
  task automatic clr();
    cmd_n = 0; dat_n = 0; stp_n = 0; syn_n = 0;
  endtask
  task automatic start_c();
    if (m_scl == 1'b0) begin
      wait_q(1); m_sda = 1'b1; wait_q(1); m_scl = 1'b1; wait_q(1);
    end
    m_sda = 1'b0; wait_q(1); m_scl = 1'b0;
  endtask
  task automatic stop_c();
    wait_q(1); m_sda = 1'b0; wait_q(1); m_scl = 1'b1; wait_q(1); m_sda = 1'b1; wait_q(2);
  endtask
  task automatic send_byte(input logic [7:0] b, input int nbits, input bit glitch, output bit ack);
    ack = 1'b0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      wait_q(1); m_sda = b[i];
      if (glitch && i == 5) begin
        @(negedge clk) m_scl = 1'b1;
        @(negedge clk) m_scl = 1'b0;
      end
      wait_q(1); m_scl = 1'b1; wait_q(2); m_scl = 1'b0;
    end
    if (nbits == 8) begin
      wait_q(1); m_sda = 1'b1; wait_q(1); m_scl = 1'b1;
      wait_q(1); ack = !sda_bus; wait_q(1); m_scl = 1'b0;
    end
  endtask

  task automatic full_frame(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
    bit a0, a1, a2, a3;
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(c, 8, 0, a1);
    send_byte(lo, 8, 0, a2);
    send_byte(hi, 8, 0, a3);
    stop_c();
    chk(a0 && a1 && a2 && a3, "R3 acks on full frame", int'({a0, a1, a2, a3}), 15);
    chk(cmd_n == 1 && last_cmd == c, "R4 command delivered", int'(last_cmd), int'(c));
    chk(dat_n == 1 && last_code == exp_code(lo, hi), "R4 code packing", int'(last_code), int'(exp_code(lo, hi)));
    chk(stp_n == 1, "R2 stop strobe", stp_n, 1);
  endtask

  task automatic cmd_frame(input logic [7:0] c);
    bit a0, a1;
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(c, 8, 0, a1);
    stop_c();
    chk(a0 && a1 && cmd_n == 1 && last_cmd == c, "R5 command-only write", int'(last_cmd), int'(c));
    chk(dat_n == 0, "R5 no data on command-only", dat_n, 0);
  endtask

  task automatic sync_frame(input bit f);
    bit a0, a1;
    clr();
    start_c();
    send_byte({7'b1111110, f}, 8, 0, a0);
    send_byte(8'hA5, 8, 0, a1);
    stop_c();
    chk(a0 && syn_n == 1 && last_flag == f, "R8 sync ack and flag", int'(last_flag), int'(f));
    chk(!a1 && cmd_n == 0 && dat_n == 0, "R8 nothing after sync", int'(a1), 0);
  endtask

  task automatic early_cut(input logic [7:0] c, input int nb);
    bit a0, a1;
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(c, nb, 0, a1);
    stop_c();
    chk(cmd_n == 0 && dat_n == 0, "R6 partial command dropped", cmd_n, 0);
  endtask

  task automatic mid_cut(input logic [7:0] c, input logic [7:0] lo, input int nb);
    bit a0, a1, a2;
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(c, 8, 0, a1);
    send_byte(lo, nb, 0, a2);
    stop_c();
    chk(cmd_n == 1 && last_cmd == c, "R7 command kept on cut", int'(last_cmd), int'(c));
    chk(dat_n == 0, "R7 data dropped on cut", dat_n, 0);
  endtask

  initial begin
    bit a0, a1, a2, a3, a4;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk(sda_oe == 0 && cmd_valid == 0 && data_valid == 0 && stop_seen == 0 && sync_ack == 0,
        "R12 strobes low in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cmd_byte == 0 && data_code == 0 && sync_flag == 0 && sda_oe == 0,
        "R12 reset values", int'(data_code), 0);

    strap = 3'b101;
    full_frame(8'h3C, 8'hFF, 8'hFF);
    full_frame(8'h00, 8'h12, 8'hFC);
    chk(last_code == 10'h012, "R4 high byte upper bits ignored", int'(last_code), 'h012);
    cmd_frame(8'h81);
    sync_frame(1'b1);
    sync_frame(1'b0);
    early_cut(8'hAA, 4);
    early_cut(8'h55, 8'd7);
    mid_cut(8'h07, 8'h44, 8);
    mid_cut(8'h06, 8'h44, 3);

    // R7 cut by repeated START, followed by a fresh full frame
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(8'h11, 8, 0, a1);
    send_byte(8'h22, 8, 0, a2);
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(8'h33, 8, 0, a1);
    send_byte(8'h9D, 8, 0, a2);
    send_byte(8'h02, 8, 0, a3);
    stop_c();
    chk(cmd_n == 2 && dat_n == 1, "R7 repeated start keeps command", cmd_n * 10 + dat_n, 21);
    chk(last_code == 10'h29D && last_cmd == 8'h33, "R7 later frame code", int'(last_code), 'h29D);
    chk(stp_n == 1, "R2 one stop per stop", stp_n, 1);

    // R1 wrong strap, read bit, foreign address
    clr();
    start_c();
    send_byte({4'b0100, 3'b100, 1'b0}, 8, 0, a0);
    send_byte(8'h44, 8, 0, a1);
    stop_c();
    chk(!a0 && !a1 && cmd_n == 0, "R1 other strap not acked", int'({a0, a1}), 0);
    clr();
    start_c();
    send_byte({4'b0100, strap, 1'b1}, 8, 0, a0);
    send_byte(8'h44, 8, 0, a1);
    stop_c();
    chk(!a0 && !a1 && cmd_n == 0, "R1 read bit not acked", int'({a0, a1}), 0);
    clr();
    start_c();
    send_byte({4'b0011, strap, 1'b0}, 8, 0, a0);
    stop_c();
    chk(!a0 && stp_n == 1, "R1 foreign prefix not acked", int'(a0), 0);

    // R11 trailing byte
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(8'h10, 8, 0, a1);
    send_byte(8'h20, 8, 0, a2);
    send_byte(8'h01, 8, 0, a3);
    send_byte(8'hEE, 8, 0, a4);
    stop_c();
    chk(!a4 && cmd_n == 1 && dat_n == 1, "R11 extra byte not acked", int'(a4), 0);

    // R10 glitch on SCL inside the command byte
    clr();
    start_c();
    send_byte(own_w(strap), 8, 0, a0);
    send_byte(8'hC3, 8, 1, a1);
    stop_c();
    chk(a1 && cmd_n == 1 && last_cmd == 8'hC3, "R10 glitch ignored", int'(last_cmd), 'hC3);

    for (int k = 0; k < 30; k++) begin
      int kind;
      logic [7:0] c, lo, hi;
      kind = $urandom_range(0, 4);
      c = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom);
      strap = 3'($urandom);
      case (kind)
        0: full_frame(c, lo, hi);
        1: cmd_frame(c);
        2: sync_frame(c[0]);
        3: early_cut(c, $urandom_range(1, 7));
        default: mid_cut(c, lo, $urandom_range(1, 8));
      endcase
    end
    chk(multi_n == 0, "R9 strobes never overlap", multi_n, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule